// File: doc/BRIEF.md
# Dual-Register Output Logic Cell

This block is one output logic cell of a small programmable logic device. It holds two flip-flops that work independently of each other. Each one takes a sum-term data input, an asynchronous reset term and a clock. Per-register configuration bits decide whether the flip-flop loads its sum term (D behaviour) or toggles when the sum term is high (T behaviour). Further configuration bits decide whether it is clocked by the shared dedicated clock pin or by its own product-term clock. A single synchronous preset input is shared by the registers, and a global power-up reset clears both.

One of the two registers is chosen by a configuration bit to drive a bidirectional pin, with selectable polarity. A separate output-enable term controls the pin. When that term is low the pin is released, so the cell can take in an outside value. Both register states always reach the array on their own feedback outputs, and the pin value reaches it on a separate input path. This lets a buried register and a pin input share one cell.

Top module: `dual_reg_macrocell`

## Requirements
- R1: While `por_n` is low, both registers read 0 whatever the clocks, sum terms and preset are doing.
- R2: With `cfg_toggle[i]`=0, register i loads `sum_term[i]` on its active clock edge.
- R3: With `cfg_toggle[i]`=1, register i inverts its value on its active clock edge when `sum_term[i]` is 1, and holds it when `sum_term[i]` is 0.
- R4: With `cfg_ptclk[i]`=1, register i is clocked only by rising edges of `pt_clk[i]` and ignores `clk_pin`. With `cfg_ptclk[i]`=0, it is clocked only by `clk_pin` and ignores `pt_clk[i]`. The two registers may use different sources.
- R5: While `rst_term[i]` is high, register i reads 0 at once, with no clock edge needed, and the other register is not affected.
- R6: `spre` high at a register's active clock edge sets that register to 1 in both D and T mode. `spre` has no effect between edges, and none on a register whose own clock does not tick.
- R7: When `rst_term[i]` and `spre` are both high, register i stays 0.
- R8: When `oe_term` is 1, the pin carries `fb[cfg_drive_sel] ^ cfg_invert`. Select value 0 picks register 0 and value 1 picks register 1.
- R9: When `oe_term` is 0, the cell releases the pin. `pin_in` then follows the outside driver, and `fb` depends only on the registers and never on the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pin | input | 1 | Shared dedicated clock pin |
| por_n | input | 1 | Global power-up reset, active low, asynchronous |
| sum_term | input | N_REG | Per-register sum-term data |
| pt_clk | input | N_REG | Per-register product-term clock |
| rst_term | input | N_REG | Per-register asynchronous reset term, active high |
| cfg_toggle | input | N_REG | Per-register mode: 1 = T, 0 = D |
| cfg_ptclk | input | N_REG | Per-register clock source: 1 = product term, 0 = clock pin |
| spre | input | 1 | Shared synchronous preset |
| oe_term | input | 1 | Output-enable term for the pin |
| cfg_drive_sel | input | SEL_W | Register that drives the pin |
| cfg_invert | input | 1 | 1 = drive the pin with the inverted register value |
| pin_io | inout | 1 | Bidirectional device pin |
| pin_in | output | 1 | Input path from the pin into the array |
| fb | output | N_REG | Register feedback into the array |

## Verification
D-mode loads are run through all four two-bit sum patterns, which shows that the two registers keep their data apart. A T-mode sequence of toggle and hold patterns tells inversion apart from loading. With the registers set to opposite clock sources, product-term pulses placed off the pin-clock edges show which clock each register follows. Reset and preset are applied with and without an edge, and together, so that the bench can tell a level-acting reset from an edge-acting preset and see which one wins. With the output released, the pin is driven from outside to the value opposite to the register's, which shows that the pin input and the feedback are separate.

// File: rtl/dual_reg_macrocell.sv
module dual_reg_macrocell #(
  parameter int N_REG = 2,
  parameter int SEL_W = (N_REG > 1) ? $clog2(N_REG) : 1
) (
  input  logic             clk_pin,
  input  logic             por_n,
  input  logic [N_REG-1:0] sum_term,
  input  logic [N_REG-1:0] pt_clk,
  input  logic [N_REG-1:0] rst_term,
  input  logic [N_REG-1:0] cfg_toggle,
  input  logic [N_REG-1:0] cfg_ptclk,
  input  logic             spre,
  input  logic             oe_term,
  input  logic [SEL_W-1:0] cfg_drive_sel,
  input  logic             cfg_invert,
  inout  wire              pin_io,
  output logic             pin_in,
  output logic [N_REG-1:0] fb
);

  logic drive_val;

  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    logic reg_clk;
    logic clr;
    logic nxt;
    logic q;

    assign reg_clk = cfg_ptclk[i] ? pt_clk[i] : clk_pin;
    assign clr     = rst_term[i] | ~por_n;
    assign nxt     = spre ? 1'b1 : (cfg_toggle[i] ? (q ^ sum_term[i]) : sum_term[i]);

    always_ff @(posedge reg_clk or posedge clr) begin
      if (clr) q <= 1'b0;
      else     q <= nxt;
    end

    assign fb[i] = q;
  end

  assign drive_val = fb[cfg_drive_sel] ^ cfg_invert;
  assign pin_io    = oe_term ? drive_val : 1'bz;
  assign pin_in    = pin_io;

endmodule

module dual_reg_macrocell_chk #(
  parameter int N_REG = 2,
  parameter int SEL_W = (N_REG > 1) ? $clog2(N_REG) : 1
) (
  input logic             clk_pin,
  input logic             por_n,
  input logic [N_REG-1:0] sum_term,
  input logic [N_REG-1:0] rst_term,
  input logic [N_REG-1:0] cfg_toggle,
  input logic [N_REG-1:0] cfg_ptclk,
  input logic             spre,
  input logic             oe_term,
  input logic [SEL_W-1:0] cfg_drive_sel,
  input logic             cfg_invert,
  input logic             pin_io,
  input logic [N_REG-1:0] fb
);

  for (genvar i = 0; i < N_REG; i++) begin : g_chk
    p_async_clear_r5: assert property (@(posedge clk_pin) disable iff (!por_n)
      rst_term[i] |-> !fb[i]);

    p_d_load_r2: assert property (@(posedge clk_pin) disable iff (!por_n)
      (!cfg_ptclk[i] && !cfg_toggle[i] && !spre && !rst_term[i]) |=>
      (rst_term[i] || !$stable(cfg_toggle[i]) || !$stable(cfg_ptclk[i]) ||
       fb[i] == $past(sum_term[i])));

    p_t_toggle_r3: assert property (@(posedge clk_pin) disable iff (!por_n)
      (!cfg_ptclk[i] && cfg_toggle[i] && !spre && !rst_term[i]) |=>
      (rst_term[i] || !$stable(cfg_toggle[i]) || !$stable(cfg_ptclk[i]) ||
       fb[i] == ($past(fb[i]) ^ $past(sum_term[i]))));

    p_preset_r6: assert property (@(posedge clk_pin) disable iff (!por_n)
      (!cfg_ptclk[i] && spre && !rst_term[i]) |=>
      (rst_term[i] || !$stable(cfg_ptclk[i]) || fb[i]));
  end

  p_pin_drive_r8: assert property (@(posedge clk_pin) disable iff (!por_n)
    oe_term |-> (pin_io == (fb[cfg_drive_sel] ^ cfg_invert)));

endmodule

bind dual_reg_macrocell dual_reg_macrocell_chk #(.N_REG(N_REG), .SEL_W(SEL_W)) u_chk (
  .clk_pin(clk_pin), .por_n(por_n), .sum_term(sum_term), .rst_term(rst_term),
  .cfg_toggle(cfg_toggle), .cfg_ptclk(cfg_ptclk), .spre(spre), .oe_term(oe_term),
  .cfg_drive_sel(cfg_drive_sel), .cfg_invert(cfg_invert), .pin_io(pin_io), .fb(fb)
);

// File: tb/tb_dual_reg_macrocell.sv
module tb_dual_reg_macrocell;
  logic       clk_pin = 1'b0;
  logic       por_n = 1'b0;
  logic [1:0] sum_term = '0;
  logic [1:0] pt_clk = '0;
  logic [1:0] rst_term = '0;
  logic [1:0] cfg_toggle = '0;
  logic [1:0] cfg_ptclk = '0;
  logic       spre = 1'b0;
  logic       oe_term = 1'b0;
  logic [0:0] cfg_drive_sel = '0;
  logic       cfg_invert = 1'b0;
  logic       ext_en = 1'b0;
  logic       ext_drv = 1'b0;
  wire        pin_io;
  logic       pin_in;
  logic [1:0] fb;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  assign pin_io = ext_en ? ext_drv : 1'bz;

  dual_reg_macrocell dut (
    .clk_pin(clk_pin), .por_n(por_n), .sum_term(sum_term), .pt_clk(pt_clk),
    .rst_term(rst_term), .cfg_toggle(cfg_toggle), .cfg_ptclk(cfg_ptclk), .spre(spre),
    .oe_term(oe_term), .cfg_drive_sel(cfg_drive_sel), .cfg_invert(cfg_invert),
    .pin_io(pin_io), .pin_in(pin_in), .fb(fb)
  );

  always #10 clk_pin = ~clk_pin;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pt_pulse(input int idx);
    #3 pt_clk[idx] = 1'b1;
    #4 pt_clk[idx] = 1'b0;
  endtask

  task automatic edge_settle();
    @(posedge clk_pin);
    #2;
  endtask

  task automatic t_reset();
    sum_term = 2'b11;
    spre = 1'b1;
    oe_term = 1'b1;
    edge_settle();
    @(negedge clk_pin);
    pt_pulse(0);
    pt_pulse(1);
    edge_settle();
    chk("R1 regs during por", fb, 2'b00);
    chk("R1 pin during por", pin_in, 1'b0);
    @(negedge clk_pin);
    spre = 1'b0;
    oe_term = 1'b0;
    sum_term = 2'b00;
    por_n = 1'b1;
  endtask

  task automatic t_dmode();
    logic [1:0] pats [4] = '{2'b01, 2'b10, 2'b11, 2'b00};
    foreach (pats[k]) begin
      @(negedge clk_pin);
      sum_term = pats[k];
      edge_settle();
      chk("R2 d load", fb, pats[k]);
    end
  endtask

  task automatic t_tmode();
    logic [1:0] sums [4] = '{2'b11, 2'b01, 2'b00, 2'b10};
    logic [1:0] exps [4] = '{2'b11, 2'b10, 2'b10, 2'b00};
    @(negedge clk_pin);
    cfg_toggle = 2'b11;
    sum_term = 2'b00;
    edge_settle();
    chk("R3 t hold", fb, 2'b00);
    foreach (sums[k]) begin
      @(negedge clk_pin);
      sum_term = sums[k];
      edge_settle();
      chk("R3 t step", fb, exps[k]);
    end
  endtask

  task automatic t_clksrc();
    @(negedge clk_pin);
    cfg_toggle = 2'b00;
    cfg_ptclk = 2'b01;
    sum_term = 2'b11;
    edge_settle();
    chk("R4 reg0 ignores pin clock", fb, 2'b10);
    @(negedge clk_pin);
    pt_pulse(0);
    #1;
    chk("R4 reg0 takes pt clock", fb, 2'b11);
    @(negedge clk_pin);
    sum_term = 2'b00;
    pt_pulse(1);
    #1;
    chk("R4 reg1 ignores pt clock", fb, 2'b11);
    edge_settle();
    chk("R4 separate clocks", fb, 2'b01);
  endtask

  task automatic t_async();
    @(negedge clk_pin);
    #5 rst_term[0] = 1'b1;
    #1;
    chk("R5 immediate clear", fb, 2'b00);
    sum_term = 2'b01;
    pt_pulse(0);
    #1;
    chk("R5 clear holds over edge", fb, 2'b00);
    rst_term[0] = 1'b0;
    #1;
    chk("R5 release no edge", fb, 2'b00);
    @(negedge clk_pin);
    pt_pulse(0);
    #1;
    chk("R5 reload after release", fb, 2'b01);
    @(negedge clk_pin);
    sum_term = 2'b11;
    edge_settle();
    chk("R5 setup", fb, 2'b11);
    @(negedge clk_pin);
    #3 rst_term[1] = 1'b1;
    #1;
    chk("R5 other reg untouched", fb, 2'b01);
    edge_settle();
    chk("R5 clear ignores clock", fb, 2'b01);
    @(negedge clk_pin);
    rst_term[1] = 1'b0;
  endtask

  task automatic t_preset();
    @(negedge clk_pin);
    sum_term = 2'b00;
    pt_pulse(0);
    edge_settle();
    chk("R6 setup", fb, 2'b00);
    @(negedge clk_pin);
    spre = 1'b1;
    #2;
    chk("R6 no edge no effect", fb, 2'b00);
    edge_settle();
    chk("R6 preset on own edge only", fb, 2'b10);
    @(negedge clk_pin);
    pt_pulse(0);
    #1;
    chk("R6 preset on pt edge", fb, 2'b11);
    @(negedge clk_pin);
    spre = 1'b0;
    cfg_toggle = 2'b11;
    sum_term = 2'b11;
    edge_settle();
    chk("R6 toggle before preset", fb, 2'b01);
    @(negedge clk_pin);
    spre = 1'b1;
    edge_settle();
    chk("R6 preset over toggle", fb, 2'b11);
  endtask

  task automatic t_priority();
    @(negedge clk_pin);
    rst_term[1] = 1'b1;
    edge_settle();
    chk("R7 reset beats preset", fb, 2'b01);
    @(negedge clk_pin);
    rst_term[1] = 1'b0;
    spre = 1'b0;
    cfg_toggle = 2'b00;
    cfg_ptclk = 2'b00;
    sum_term = 2'b01;
  endtask

  task automatic t_output();
    logic [1:0] sel_inv [4] = '{2'b00, 2'b10, 2'b01, 2'b11};
    logic       exps [4]    = '{1'b1, 1'b0, 1'b0, 1'b1};
    edge_settle();
    chk("R8 setup", fb, 2'b01);
    foreach (sel_inv[k]) begin
      @(negedge clk_pin);
      oe_term = 1'b1;
      cfg_drive_sel = sel_inv[k][1];
      cfg_invert = sel_inv[k][0];
      #2;
      chk("R8 pin drive", pin_in, exps[k]);
    end
  endtask

  task automatic t_hiz();
    @(negedge clk_pin);
    cfg_drive_sel = 1'b1;
    cfg_invert = 1'b0;
    oe_term = 1'b0;
    #1 ext_en = 1'b1;
    ext_drv = 1'b1;
    #1;
    chk("R9 pin released", pin_in, 1'b1);
    chk("R9 fb untouched", fb, 2'b01);
    @(negedge clk_pin);
    sum_term = 2'b10;
    edge_settle();
    chk("R9 fb follows regs", fb, 2'b10);
    ext_drv = 1'b0;
    #1;
    chk("R9 pin input path", pin_in, 1'b0);
    chk("R9 fb independent of pin", fb, 2'b10);
    ext_en = 1'b0;
    oe_term = 1'b1;
    #1;
    chk("R8 drive resumes", pin_in, 1'b1);
  endtask

  initial begin
    t_reset();
    t_dmode();
    t_tmode();
    t_clksrc();
    t_async();
    t_preset();
    t_priority();
    t_output();
    t_hiz();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule